// File: doc/BRIEF.md
# Single-Bit Operation Unit with Bit-Addressable Byte Store

This block executes one-bit instructions against a small internal byte store that holds a bit-addressable RAM window and a group of special-function registers. A one-bit accumulator, the carry, lives in bit 7 of the status-word register at byte address D0h. The carry can be moved to or from any addressed bit, combined with a bit by AND or OR, cleared, set or inverted. Any addressed bit can be cleared, set or inverted the same way. Jump-on-bit operations only report a branch decision. The test-and-clear form also zeroes the bit it tested.

An operation starts with a one-cycle strobe that carries an opcode and an 8-bit bit address. The unit reads the whole target byte in one cycle. In the next cycle it writes the byte back with only the addressed bit changed, and it updates the carry and the branch flag in that same cycle. A byte-wide port lets the surrounding logic load and inspect the store between operations.

Top module: `bitop_unit`

## Requirements
- R1: After reset, carry, branch_taken, busy and done are 0 and every byte of the store reads 0.
- R2: A bit address below 80h selects bit addr[2:0] of RAM byte 20h + addr[6:3]. A bit address of 80h or above selects bit addr[2:0] of the register at byte address (addr AND F8h).
- R3: byte_rdata returns the stored byte for byte addresses 20h–2Fh, and for addresses 80h–FFh whose low three bits are 0. All other addresses read 0, and writes to them are dropped. An accepted write is visible from the next clock edge.
- R4: start is accepted only while busy is 0. The results (store, carry, branch_taken) change on the third rising edge counted from the accepting edge. busy is high for the two cycles between those edges. done is high for exactly the one cycle after the result edge. A start seen while busy is ignored.
- R5: carry always equals bit 7 of byte D0h. A byte write to D0h changes carry. Bit address D7h names the carry.
- R6: Opcode 0 copies the bit into carry. Opcode 1 copies carry into the bit.
- R7: Opcode 2 sets carry to carry AND bit. Opcode 3 sets carry to carry OR bit.
- R8: Opcodes 4, 5 and 6 clear, set and invert the addressed bit. The other seven bits of that byte keep their values.
- R9: Opcodes 7, 8 and 9 clear, set and invert the carry. No other stored bit changes.
- R10: Opcode 10 raises branch_taken when the bit is 1. Opcode 11 raises it when the bit is 0. Neither changes the store. Every other non-jump opcode leaves branch_taken at 0. The flag holds until the next operation completes.
- R11: Opcode 12 raises branch_taken and clears the bit when the bit is 1. When the bit is 0 it leaves the bit unchanged and branch_taken at 0.
- R12: Opcodes 13–15 change neither the store nor the carry, and leave branch_taken at 0.
- R13: A byte write presented while busy is 1 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle operation strobe |
| op | input | 4 | Opcode, encoded as listed in R6–R12 |
| bit_addr | input | 8 | Bit address of the operand |
| byte_we | input | 1 | Byte write enable |
| byte_waddr | input | 8 | Byte write address |
| byte_wdata | input | 8 | Byte write data |
| byte_raddr | input | 8 | Byte read address |
| byte_rdata | output | 8 | Combinational byte read data |
| carry | output | 1 | One-bit accumulator (bit 7 of D0h) |
| branch_taken | output | 1 | Branch decision of the last completed operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions take some things for granted about the inputs. Reset opens every run. The store changes only through the write port, and only while the unit is idle. The property that carry holds across a bit-only commit therefore depends on no byte write landing inside an operation. The stimulus keeps to this in its random phase by issuing byte writes only between operations. It breaks the rule on purpose only in a directed case, which checks that such a write is dropped. Random opcodes cover the full 4-bit range, including the unused codes. Random addresses cover both halves of the bit space, with the status-word bits included, so the carry-alias paths are reached.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

   typedef enum logic [3:0] {
      BOP_MOV_C_BIT = 4'd0,
      BOP_MOV_BIT_C = 4'd1,
      BOP_AND_C     = 4'd2,
      BOP_OR_C      = 4'd3,
      BOP_CLR_BIT   = 4'd4,
      BOP_SET_BIT   = 4'd5,
      BOP_INV_BIT   = 4'd6,
      BOP_CLR_C     = 4'd7,
      BOP_SET_C     = 4'd8,
      BOP_INV_C     = 4'd9,
      BOP_JMP_SET   = 4'd10,
      BOP_JMP_CLR   = 4'd11,
      BOP_JMP_TCLR  = 4'd12
   } bop_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FETCH  = 2'd1,
      ST_COMMIT = 2'd2
   } bop_state_e;

endpackage

// File: rtl/bitop_byte_dec.sv
module bitop_byte_dec #(
   parameter int AW       = 8,
   parameter int DW       = 8,
   parameter int RAM_BASE = 32
) (
   input  logic [AW-1:0]                addr,
   output logic                         hit,
   output logic [AW-$clog2(DW)-1:0]     sel
);
   localparam int IDX_W     = $clog2(DW);
   localparam int GRP_W     = AW - 1 - IDX_W;
   localparam int RAM_BYTES = 2 ** GRP_W;

   logic [AW-1:0] off;
   logic          ram_hit;
   logic          sfr_hit;

   assign off     = addr - AW'(RAM_BASE);
   assign ram_hit = !addr[AW-1] && (addr >= AW'(RAM_BASE)) && (off < AW'(RAM_BYTES));
   assign sfr_hit = addr[AW-1] && (addr[IDX_W-1:0] == '0);
   assign hit     = ram_hit || sfr_hit;
   assign sel     = ram_hit ? {1'b0, off[GRP_W-1:0]} : {1'b1, addr[AW-2:IDX_W]};

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
   import bitop_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic [3:0]            op,
   input  logic [DW-1:0]         byte_in,
   input  logic [$clog2(DW)-1:0] pos,
   input  logic                  c_in,
   output logic [DW-1:0]         byte_out,
   output logic                  byte_we,
   output logic                  c_out,
   output logic                  c_we,
   output logic                  branch
);
   logic b;

   always_comb begin
      b        = byte_in[pos];
      byte_out = byte_in;
      byte_we  = 1'b0;
      c_out    = c_in;
      c_we     = 1'b0;
      branch   = 1'b0;
      case (op)
         BOP_MOV_C_BIT: begin c_out = b;          c_we = 1'b1; end
         BOP_MOV_BIT_C: begin byte_out[pos] = c_in; byte_we = 1'b1; end
         BOP_AND_C:     begin c_out = c_in & b;   c_we = 1'b1; end
         BOP_OR_C:      begin c_out = c_in | b;   c_we = 1'b1; end
         BOP_CLR_BIT:   begin byte_out[pos] = 1'b0; byte_we = 1'b1; end
         BOP_SET_BIT:   begin byte_out[pos] = 1'b1; byte_we = 1'b1; end
         BOP_INV_BIT:   begin byte_out[pos] = ~b;   byte_we = 1'b1; end
         BOP_CLR_C:     begin c_out = 1'b0;       c_we = 1'b1; end
         BOP_SET_C:     begin c_out = 1'b1;       c_we = 1'b1; end
         BOP_INV_C:     begin c_out = ~c_in;      c_we = 1'b1; end
         BOP_JMP_SET:   branch = b;
         BOP_JMP_CLR:   branch = ~b;
         BOP_JMP_TCLR:  begin
            branch        = b;
            byte_out[pos] = 1'b0;
            byte_we       = b;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/bitop_store.sv
module bitop_store #(
   parameter int NB        = 32,
   parameter int DW        = 8,
   parameter int SEL_W     = 5,
   parameter int PSW_SEL   = 26,
   parameter int CARRY_BIT = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock,
   input  logic             ext_we,
   input  logic             ext_hit,
   input  logic [SEL_W-1:0] ext_sel,
   input  logic [DW-1:0]    ext_wdata,
   input  logic             rd_hit,
   input  logic [SEL_W-1:0] rd_sel,
   output logic [DW-1:0]    rd_data,
   input  logic [SEL_W-1:0] core_sel,
   output logic [DW-1:0]    core_rdata,
   input  logic             core_we,
   input  logic [DW-1:0]    core_wdata,
   input  logic             carry_we,
   input  logic             carry_val,
   output logic             carry_o
);
   logic [NB-1:0][DW-1:0] mem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_q <= '0;
      end else begin
         for (int i = 0; i < NB; i++) begin
            if (core_we && core_sel == SEL_W'(i))
               mem_q[i] <= core_wdata;
            else if (ext_we && ext_hit && !lock && ext_sel == SEL_W'(i))
               mem_q[i] <= ext_wdata;
            if (i == PSW_SEL && carry_we)
               mem_q[i][CARRY_BIT] <= carry_val;
         end
      end
   end

   assign rd_data    = rd_hit ? mem_q[rd_sel] : '0;
   assign core_rdata = mem_q[core_sel];
   assign carry_o    = mem_q[PSW_SEL][CARRY_BIT];

   // R13: while an operation holds the store and is not committing, nothing moves
   assert_store_locked_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && !core_we && !carry_we) |=> $stable(mem_q));

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
   import bitop_pkg::*;
#(
   parameter int            AW        = 8,
   parameter int            DW        = 8,
   parameter int            RAM_BASE  = 32,
   parameter logic [AW-1:0] PSW_ADDR  = 8'hD0,
   parameter int            CARRY_BIT = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [3:0]    op,
   input  logic [AW-1:0] bit_addr,
   input  logic          byte_we,
   input  logic [AW-1:0] byte_waddr,
   input  logic [DW-1:0] byte_wdata,
   input  logic [AW-1:0] byte_raddr,
   output logic [DW-1:0] byte_rdata,
   output logic          carry,
   output logic          branch_taken,
   output logic          busy,
   output logic          done
);
   localparam int IDX_W     = $clog2(DW);
   localparam int GRP_W     = AW - 1 - IDX_W;
   localparam int SEL_W     = GRP_W + 1;
   localparam int NB        = 2 ** SEL_W;
   localparam int RAM_BYTES = 2 ** GRP_W;
   localparam int PSW_SEL   = int'({1'b1, PSW_ADDR[AW-2:IDX_W]});

   if (DW != 2 ** IDX_W) begin : g_bad_dw
      $error("data width must be a power of two");
   end
   if (!PSW_ADDR[AW-1] || PSW_ADDR[IDX_W-1:0] != '0) begin : g_bad_psw
      $error("status word must sit on a bit-addressable register address");
   end
   if (RAM_BASE + RAM_BYTES > 2 ** (AW - 1)) begin : g_bad_ram
      $error("RAM window must lie in the lower half of the byte space");
   end
   if (CARRY_BIT >= DW) begin : g_bad_carry
      $error("carry bit position out of range");
   end

   bop_state_e           state_q;
   logic [3:0]           op_q;
   logic [AW-1:0]        addr_q;
   logic [DW-1:0]        byte_q;
   logic                 c_q;
   logic                 branch_q;
   logic                 done_q;

   logic [SEL_W-1:0]     bit_sel;
   logic [IDX_W-1:0]     bit_pos;
   logic [DW-1:0]        fetch_byte;
   logic [DW-1:0]        new_byte;
   logic                 new_byte_we;
   logic                 new_c;
   logic                 new_c_we;
   logic                 new_branch;
   logic                 commit;
   logic                 accept;
   logic                 is_jump;

   logic [1:0][AW-1:0]    dec_addr;
   logic [1:0]            dec_hit;
   logic [1:0][SEL_W-1:0] dec_sel;

   assign dec_addr[0] = byte_waddr;
   assign dec_addr[1] = byte_raddr;

   for (genvar g = 0; g < 2; g++) begin : g_dec
      bitop_byte_dec #(.AW(AW), .DW(DW), .RAM_BASE(RAM_BASE)) u_dec (
         .addr (dec_addr[g]),
         .hit  (dec_hit[g]),
         .sel  (dec_sel[g])
      );
   end

   assign bit_sel = {addr_q[AW-1], addr_q[AW-2:IDX_W]};
   assign bit_pos = addr_q[IDX_W-1:0];
   assign accept  = start && (state_q == ST_IDLE);
   assign commit  = (state_q == ST_COMMIT);
   assign is_jump = (op_q == BOP_JMP_SET) || (op_q == BOP_JMP_CLR) || (op_q == BOP_JMP_TCLR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         op_q     <= '0;
         addr_q   <= '0;
         byte_q   <= '0;
         c_q      <= 1'b0;
         branch_q <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (accept) begin
               op_q    <= op;
               addr_q  <= bit_addr;
               state_q <= ST_FETCH;
            end
            ST_FETCH: begin
               byte_q  <= fetch_byte;
               c_q     <= carry;
               state_q <= ST_COMMIT;
            end
            ST_COMMIT: begin
               branch_q <= new_branch;
               done_q   <= 1'b1;
               state_q  <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   bitop_alu #(.DW(DW)) u_alu (
      .op       (op_q),
      .byte_in  (byte_q),
      .pos      (bit_pos),
      .c_in     (c_q),
      .byte_out (new_byte),
      .byte_we  (new_byte_we),
      .c_out    (new_c),
      .c_we     (new_c_we),
      .branch   (new_branch)
   );

   bitop_store #(
      .NB(NB), .DW(DW), .SEL_W(SEL_W), .PSW_SEL(PSW_SEL), .CARRY_BIT(CARRY_BIT)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .lock       (busy),
      .ext_we     (byte_we),
      .ext_hit    (dec_hit[0]),
      .ext_sel    (dec_sel[0]),
      .ext_wdata  (byte_wdata),
      .rd_hit     (dec_hit[1]),
      .rd_sel     (dec_sel[1]),
      .rd_data    (byte_rdata),
      .core_sel   (bit_sel),
      .core_rdata (fetch_byte),
      .core_we    (commit && new_byte_we),
      .core_wdata (new_byte),
      .carry_we   (commit && new_c_we),
      .carry_val  (new_c),
      .carry_o    (carry)
   );

   assign busy         = (state_q != ST_IDLE);
   assign branch_taken = branch_q;
   assign done         = done_q;

   // R4: an accepted strobe makes the unit busy and completes three edges later
   assert_accept_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy);
   assert_done_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> ##3 done);

   // R8: the write-back differs from the fetched byte in at most the addressed bit
   assert_single_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> ($countones(new_byte ^ byte_q) <= 1));

   // R9: a commit that neither writes carry nor touches the status byte keeps carry
   assert_carry_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !new_c_we && !(new_byte_we && bit_sel == SEL_W'(PSW_SEL))) |=> $stable(carry));

   // R10: non-jump operations leave the branch flag low
   assert_branch_jump_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !is_jump) |=> !branch_taken);

endmodule

// File: tb/bitop_unit_tb_top.sv
`timescale 1ns/1ps
module bitop_unit_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [3:0] op = '0;
   logic [7:0] bit_addr = '0;
   logic       byte_we = 1'b0;
   logic [7:0] byte_waddr = '0;
   logic [7:0] byte_wdata = '0;
   logic [7:0] byte_raddr = '0;
   logic [7:0] byte_rdata;
   logic       carry, branch_taken, busy, done;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   logic [7:0] ref_mem [32];
   logic       ref_br;

   always #2.5 clk = ~clk;

   bitop_unit dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bit_addr(bit_addr),
      .byte_we(byte_we), .byte_waddr(byte_waddr), .byte_wdata(byte_wdata),
      .byte_raddr(byte_raddr), .byte_rdata(byte_rdata), .carry(carry),
      .branch_taken(branch_taken), .busy(busy), .done(done)
   );

   function automatic int sel_of(input logic [7:0] a);
      if (a >= 8'h20 && a <= 8'h2F) return int'(a) - 32;
      if (a[7] && a[2:0] == 3'b000) return 16 + int'(a[6:3]);
      return -1;
   endfunction

   function automatic logic [7:0] byte_of_bit(input logic [7:0] a);
      return a[7] ? {a[7:3], 3'b000} : 8'h20 + {4'h0, a[6:3]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic read_check(input string req, input logic [7:0] a);
      int s;
      s = sel_of(a);
      byte_raddr = a;
      #0.5;
      check(req, {24'h0, byte_rdata}, (s < 0) ? 32'h0 : {24'h0, ref_mem[s]});
   endtask

   task automatic write_byte(input logic [7:0] a, input logic [7:0] d);
      int s;
      byte_we = 1'b1; byte_waddr = a; byte_wdata = d;
      @(posedge clk);
      @(negedge clk);
      byte_we = 1'b0;
      s = sel_of(a);
      if (s >= 0) ref_mem[s] = d;
   endtask

   task automatic model_op(input logic [3:0] o, input logic [7:0] a);
      int s;
      logic b, c;
      s = sel_of(byte_of_bit(a));
      b = ref_mem[s][a[2:0]];
      c = ref_mem[26][7];
      ref_br = 1'b0;
      case (o)
         4'd0: ref_mem[26][7] = b;
         4'd1: ref_mem[s][a[2:0]] = c;
         4'd2: ref_mem[26][7] = c & b;
         4'd3: ref_mem[26][7] = c | b;
         4'd4: ref_mem[s][a[2:0]] = 1'b0;
         4'd5: ref_mem[s][a[2:0]] = 1'b1;
         4'd6: ref_mem[s][a[2:0]] = ~b;
         4'd7: ref_mem[26][7] = 1'b0;
         4'd8: ref_mem[26][7] = 1'b1;
         4'd9: ref_mem[26][7] = ~c;
         4'd10: ref_br = b;
         4'd11: ref_br = ~b;
         4'd12: begin ref_br = b; ref_mem[s][a[2:0]] = 1'b0; end
         default: ;
      endcase
   endtask

   function automatic string req_of(input logic [3:0] o);
      case (o)
         4'd0, 4'd1: return "R6";
         4'd2, 4'd3: return "R7";
         4'd4, 4'd5, 4'd6: return "R8";
         4'd7, 4'd8, 4'd9: return "R9";
         4'd10, 4'd11: return "R10";
         4'd12: return "R11";
         default: return "R12";
      endcase
   endfunction

   task automatic run_op(input logic [3:0] o, input logic [7:0] a);
      string r;
      r = req_of(o);
      model_op(o, a);
      start = 1'b1; op = o; bit_addr = a;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      check("R4 busy", {31'h0, busy}, 32'h1);
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      check("R4 done", {31'h0, done}, 32'h1);
      check({r, " carry R5"}, {31'h0, carry}, {31'h0, ref_mem[26][7]});
      check({r, " branch"}, {31'h0, branch_taken}, {31'h0, ref_br});
      read_check({r, " target byte R2"}, byte_of_bit(a));
      read_check({r, " status byte"}, 8'hD0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 32; i++) ref_mem[i] = 8'h00;
      ref_br = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1 carry", {31'h0, carry}, 32'h0);
      check("R1 branch", {31'h0, branch_taken}, 32'h0);
      check("R1 busy", {31'h0, busy}, 32'h0);
      check("R1 done", {31'h0, done}, 32'h0);
      for (int a = 0; a < 256; a++) read_check("R1 byte", 8'(a));

      // R3: valid and invalid byte addresses
      write_byte(8'h20, 8'hA5);
      write_byte(8'h2F, 8'h3C);
      write_byte(8'h1F, 8'hFF);
      write_byte(8'h30, 8'hFF);
      write_byte(8'h88, 8'h5A);
      write_byte(8'h89, 8'hFF);
      read_check("R3 ram low", 8'h20);
      read_check("R3 ram high", 8'h2F);
      read_check("R3 below window", 8'h1F);
      read_check("R3 above window", 8'h30);
      read_check("R3 register", 8'h88);
      read_check("R3 unaligned register", 8'h89);

      // R5: status byte write drives carry; D7h is carry
      write_byte(8'hD0, 8'h80);
      check("R5 carry from byte", {31'h0, carry}, 32'h1);
      run_op(4'd4, 8'hD7);
      check("R5 clear D7h", {31'h0, carry}, 32'h0);
      run_op(4'd8, 8'h00);

      // R2: mapping corners
      run_op(4'd6, 8'h00);
      run_op(4'd6, 8'h7F);
      run_op(4'd5, 8'h80);
      run_op(4'd5, 8'hFF);
      run_op(4'd1, 8'h43);

      // R11: test-and-clear both ways
      run_op(4'd12, 8'h7F);
      run_op(4'd12, 8'h7F);
      // R10 jumps
      run_op(4'd10, 8'h00);
      run_op(4'd11, 8'h00);
      // R12 unused codes
      run_op(4'd13, 8'h05);
      run_op(4'd15, 8'hD7);

      // R4 / R13: start and byte write while busy are ignored
      start = 1'b1; op = 4'd5; bit_addr = 8'h08;
      model_op(4'd5, 8'h08);
      @(posedge clk);
      @(negedge clk);
      start = 1'b1; op = 4'd5; bit_addr = 8'h10;
      byte_we = 1'b1; byte_waddr = 8'h24; byte_wdata = 8'hEE;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0; byte_we = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R4 done after ignored start", {31'h0, done}, 32'h1);
      read_check("R4 second start ignored", 8'h22);
      read_check("R13 write while busy", 8'h24);
      read_check("R8 first op applied", 8'h21);
      @(negedge clk);
      check("R4 done single cycle", {31'h0, done}, 32'h0);
      check("R4 idle", {31'h0, busy}, 32'h0);

      // random phase
      for (int n = 0; n < 600; n++) begin
         if (($urandom % 5) == 0)
            write_byte(8'($urandom), 8'($urandom));
         if (($urandom % 4) == 0)
            run_op(4'($urandom), {5'h1A, 3'($urandom)});
         else
            run_op(4'($urandom), 8'($urandom));
      end

      for (int a = 0; a < 256; a++) read_check("R3 final sweep", 8'(a));

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule